// File: doc/BRIEF.md
# Sequenced Power-Good Flag Generator

This block raises a chain of power-good flags one after another once a supply controller has brought an output rail up. A one-cycle start pulse makes the first flag active straight away. Each later flag follows the one before it after its own programmable gap. Every gap is a fixed number of delay ticks, and each gap's 8-bit divider setting sets the tick rate from the system clock. When the last flag goes active, the block raises a low-power indication and holds it.

The controller issues a synchronous clear when any fault occurs (breaker trip, start-up timeout, or input voltage out of range). The clear drops every flag and the low-power indication at once, and it abandons any gap that is still being counted. A polarity input selects whether an active flag reads as 1 or as 0 at the outputs, so the same block can feed either sense of external flag driver.

Top module: `pgseq_top`

## Requirements
- R1: During and straight after reset, every flag is inactive and `sleep_o` is 0.
- R2: When `start_i` is high at a clock edge while no flag is active and `clr_i` is low, flag 0 becomes active at that edge.
- R3: Flag k+1 becomes active exactly (P+1)*GAP_TICKS clock edges after flag k. P is the unsigned value in bits [8k+7:8k] of `gap_div_i`, so the gap between flags 0 and 1 uses bits [7:0].
- R4: Flags become active strictly in index order, at most one per edge, and an active flag stays active until a clear.
- R5: `sleep_o` rises at the same edge as the last flag and stays high until a clear.
- R6: When `clr_i` is high at an edge, all flags are inactive and `sleep_o` is 0 after that edge. Clear takes priority over a start in the same cycle.
- R7: A clear in the middle of a gap abandons that count. No further flag becomes active until a new start, and that new start runs every gap in full from flag 0.
- R8: `start_i` has no effect while a sequence is running or has completed.
- R9: With `pol_i`=1 an active flag drives its `pg_o` bit to 1 and an inactive flag drives it to 0. With `pol_i`=0 the encoding is inverted. A change of `pol_i` takes effect in the same cycle.
- R10: Divider settings at both extremes work: P=0 gives a gap of GAP_TICKS cycles and P=255 gives 256*GAP_TICKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous fault clear |
| start_i | input | 1 | Start pulse, makes flag 0 active |
| pol_i | input | 1 | 1: active-high flags, 0: active-low flags |
| gap_div_i | input | (NFLAGS-1)*DIV_W | Per-gap divider settings, lowest gap in the lowest byte |
| pg_o | output | NFLAGS | Power-good flags, encoded by `pol_i` |
| sleep_o | output | 1 | Low-power indication after the last flag |

## Verification
The assertions assume that `clr_i` and `start_i` are sampled only at clock edges and that `gap_div_i` stays constant while a gap is being counted. The timing checks depend on that second assumption. The stimulus changes the divider settings and the polarity only while a clear is being applied or the block is idle. It also keeps the settings fixed for the whole of each measured sequence. Starts that land mid-sequence come from directed cases that check the timing is unchanged.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
    localparam int DEF_NFLAGS    = 4;
    localparam int DEF_DIV_W     = 8;
    localparam int DEF_GAP_TICKS = 255;

    // true when the vector holds only a contiguous run of ones from bit 0
    function automatic logic is_thermo(input logic [31:0] v);
        return ((v & (v + 32'd1)) == 32'd0);
    endfunction
endpackage

// File: rtl/pgseq_tick_gen.sv
module pgseq_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        cnt_d  = cnt_q + 1'b1;
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pgseq_gap_timer.sv
module pgseq_gap_timer #(
    parameter int GAP_TICKS = 255
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CNT_W = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = run_i && tick_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (!run_i || done_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pgseq_pol_drv.sv
module pgseq_pol_drv #(
    parameter int NFLAGS = 4
) (
    input  logic              pol_i,
    input  logic [NFLAGS-1:0] flags_i,
    output logic [NFLAGS-1:0] pg_o
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        assign pg_o[i] = pol_i ? flags_i[i] : ~flags_i[i];
    end
endmodule

// File: rtl/pgseq_top.sv
module pgseq_top #(
    parameter int NFLAGS    = pgseq_pkg::DEF_NFLAGS,
    parameter int DIV_W     = pgseq_pkg::DEF_DIV_W,
    parameter int GAP_TICKS = pgseq_pkg::DEF_GAP_TICKS
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      clr_i,
    input  logic                      start_i,
    input  logic                      pol_i,
    input  logic [(NFLAGS-1)*DIV_W-1:0] gap_div_i,
    output logic [NFLAGS-1:0]         pg_o,
    output logic                      sleep_o
);
    localparam int NGAPS = NFLAGS - 1;
    localparam int STG_W = $clog2(NFLAGS + 1);
    localparam int GAP_W = (NGAPS > 1) ? $clog2(NGAPS) : 1;

    typedef struct packed {
        logic [NFLAGS-1:0] flags;
        logic [STG_W-1:0]  stage;
        logic              sleep;
    } seq_t;

    seq_t s_d, s_q;

    logic [NFLAGS-1:0] flags_q;
    logic [DIV_W-1:0]  gap_arr [NGAPS];
    logic [GAP_W-1:0]  gap_idx;
    logic [DIV_W-1:0]  div_sel;
    logic              run, tick, gap_done;

    for (genvar g = 0; g < NGAPS; g++) begin : g_gap
        assign gap_arr[g] = gap_div_i[g*DIV_W +: DIV_W];
    end

    always_comb begin
        gap_idx = '0;
        for (int k = 0; k < NGAPS; k++) begin
            if (s_q.stage == STG_W'(k + 1)) begin
                gap_idx = GAP_W'(k);
            end
        end
    end

    assign div_sel = gap_arr[gap_idx];
    assign run     = (s_q.stage != '0) && (s_q.stage != STG_W'(NFLAGS)) && !clr_i;

    pgseq_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .div_i  (div_sel),
        .tick_o (tick)
    );

    pgseq_gap_timer #(.GAP_TICKS(GAP_TICKS)) gap_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .tick_i (tick),
        .done_o (gap_done)
    );

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d = '0;
        end else if ((s_q.stage == '0) && start_i) begin
            s_d.flags    = '0;
            s_d.flags[0] = 1'b1;
            s_d.stage    = STG_W'(1);
            s_d.sleep    = 1'b0;
        end else if (gap_done) begin
            for (int k = 1; k < NFLAGS; k++) begin
                if (s_q.stage == STG_W'(k)) begin
                    s_d.flags[k] = 1'b1;
                end
            end
            s_d.stage = s_q.stage + 1'b1;
            if (s_q.stage == STG_W'(NFLAGS - 1)) begin
                s_d.sleep = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags_q = s_q.flags;
    assign sleep_o = s_q.sleep;

    pgseq_pol_drv #(.NFLAGS(NFLAGS)) pol_i_drv (
        .pol_i   (pol_i),
        .flags_i (flags_q),
        .pg_o    (pg_o)
    );
endmodule

// File: rtl/pgseq_checker.sv
module pgseq_checker #(
    parameter int NFLAGS = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              clr_i,
    input logic              start_i,
    input logic              sleep_o,
    input logic [NFLAGS-1:0] flags_q
);
    AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (flags_q == '0 && !sleep_o)); // R6

    AST_START_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && start_i && flags_q == '0) |=> (flags_q == NFLAGS'(1))); // R2

    AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ($countones(flags_q) <= $countones($past(flags_q)) + 1)); // R4

    AST_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4

    AST_SLEEP_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_o |-> flags_q[NFLAGS-1]); // R5

    AST_SLEEP_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flags_q[NFLAGS-1]) |-> sleep_o); // R5

    always_comb begin
        if (rst_ni) begin
            AST_THERMO: assert (pgseq_pkg::is_thermo(32'(flags_q))); // R4
        end
    end
endmodule

bind pgseq_top pgseq_checker #(.NFLAGS(NFLAGS)) chk_i (.*);

// File: tb/pgseq_tb_top.sv
module pgseq_tb_top;
    localparam int NF = 4;
    localparam int DW = 8;
    localparam int T  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, start = 1'b0, pol = 1'b1;
    logic [(NF-1)*DW-1:0] gdiv = '0;
    logic [NF-1:0] pg;
    logic sleep;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pgseq_top #(.NFLAGS(NF), .DIV_W(DW), .GAP_TICKS(T)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .start_i(start),
        .pol_i(pol), .gap_div_i(gdiv), .pg_o(pg), .sleep_o(sleep)
    );

    // gap settings: bits [7:0] first gap, [15:8] second, [23:16] third
    localparam logic [23:0] VEC [5] = '{
        24'h00_00_00,
        24'h02_04_01,
        24'h07_00_FF,
        24'h03_03_03,
        24'hFF_01_00
    };

    function automatic logic [NF-1:0] act();
        return pol ? pg : ~pg;
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    task automatic chk(input logic ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic pulse_clr();
        clr = 1'b1; tick(); clr = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    // wait for flag k to become active, return edges counted since the previous flag
    task automatic wait_flag(input int k, input int limit, output int c);
        c = 0;
        while (!act()[k] && c < limit) begin
            tick();
            c++;
        end
    endtask

    task automatic run_seq(input logic [23:0] v);
        int c, expv;
        pulse_clr();
        gdiv = v;
        pulse_start();
        chk(act() == 4'b0001, "R2", int'(act()), 1);
        for (int k = 1; k < NF; k++) begin
            expv = (int'(v[(k-1)*DW +: DW]) + 1) * T;
            chk(sleep == 1'b0, "R5", int'(sleep), 0);
            wait_flag(k, 2000, c);
            chk(c == expv, "R3", c, expv);
            chk(act() == NF'((1 << (k + 1)) - 1), "R4", int'(act()), (1 << (k + 1)) - 1);
        end
        chk(sleep == 1'b1, "R5", int'(sleep), 1);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int c;
        tick(); tick();
        chk(pg == 4'b0000 && sleep == 1'b0, "R1", int'(pg), 0);
        rst_n = 1'b1;
        tick();
        chk(pg == 4'b0000 && sleep == 1'b0, "R1", int'(pg), 0);

        // table of gap settings, timed sequence each
        for (int i = 0; i < 5; i++) begin
            pol = (i % 2 == 0);
            run_seq(VEC[i]);
        end

        // R10: extremes of the divider
        chk((int'(VEC[0][7:0]) + 1) * T == T, "R10", (int'(VEC[0][7:0]) + 1) * T, T);
        run_seq(24'hFF_FF_00);

        // R9: polarity encoding of the live state (all active now)
        pol = 1'b1; #1;
        chk(pg == 4'b1111, "R9", int'(pg), 15);
        pol = 1'b0; #1;
        chk(pg == 4'b0000, "R9", int'(pg), 0);
        pulse_clr();
        chk(pg == 4'b1111, "R9", int'(pg), 15);
        pol = 1'b1; #1;
        chk(pg == 4'b0000, "R9", int'(pg), 0);

        // R8: start after completion changes nothing
        gdiv = 24'h00_00_00;
        pulse_start();
        for (int j = 0; j < 12; j++) tick();
        chk(act() == 4'b1111 && sleep, "R5", int'(act()), 15);
        pulse_start();
        tick();
        chk(act() == 4'b1111 && sleep, "R8", int'(act()), 15);

        // R6: clear with start in the same cycle
        clr = 1'b1; start = 1'b1; tick(); clr = 1'b0; start = 1'b0;
        chk(act() == 4'b0000 && !sleep, "R6", int'(act()), 0);
        tick();
        chk(act() == 4'b0000, "R6", int'(act()), 0);

        // R7: clear mid-gap aborts, nothing asserts afterwards
        gdiv = 24'h05_05_05;
        pulse_start();
        for (int j = 0; j < 10; j++) tick();
        pulse_clr();
        chk(act() == 4'b0000, "R7", int'(act()), 0);
        for (int j = 0; j < 200; j++) tick();
        chk(act() == 4'b0000 && !sleep, "R7", int'(act()), 0);
        // a new start runs the first gap in full
        pulse_start();
        wait_flag(1, 2000, c);
        chk(c == 6 * T, "R7", c, 6 * T);

        // R8: a start in the middle of a gap leaves the timing alone
        pulse_clr();
        gdiv = 24'h02_02_02;
        pulse_start();
        for (int j = 0; j < 4; j++) tick();
        pulse_start();
        wait_flag(1, 2000, c);
        chk(c + 5 == 3 * T, "R8", c + 5, 3 * T);
        chk(act() == 4'b0011, "R8", int'(act()), 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule